// File: doc/BRIEF.md
# Error Signaling Decision Logic

This block sits between the error detectors of a serial-link endpoint function and the logic that forwards error messages toward the host. Each cycle it may accept one detected error event. An event carries a status bit, a correctable flag, an advisory-candidate flag, a header-valid flag and a 16-bit requester ID. The block keeps three sticky status registers: device status, correctable error status and uncorrectable error status. It also holds the uncorrectable severity register. It applies the mask registers, the per-class reporting enables and the system-error enable to the event. The result is at most one message, which has a one-hot severity and the requester ID.

Uncorrectable events that are not masked also pulse a log request toward a header-log recorder. The recorder answers in the same cycle, and the answer says whether its log overflowed. After an overflow the block spends the next cycle injecting a correctable header-log-overflow error through its own correctable path. It holds off new events during that cycle. A non-fatal event flagged as advisory is reported as the correctable advisory error. An unsupported-request event follows its own enable rules.

Top module: `errSignal`

## Requirements
- R1: After reset all status registers are zero, no message or log request is pending, evReady is high, and the severity register holds 0x0317. Uncorrectable bits: 0 internal, 1 link protocol, 2 surprise down, 3 poisoned, 4 flow-control protocol, 5 completion timeout, 6 completer abort, 7 unexpected completion, 8 receiver overflow, 9 malformed, 10 end-to-end CRC, 11 unsupported request, 12 to 15 other non-fatal errors.
- R2: The event status is first masked to the supported bits of its class. The correctable class uses the low 8 bits only. If the masked value is not exactly one bit, the event has no effect on any status bit, message or log request.
- R3: A correctable event sets device status bit 0 and its correctable status bit. Correctable bits: 5 advisory non-fatal, 7 header log overflow. When its correctable mask bit is clear and corRptEn is high, it sends a message with severity 3'b001.
- R4: An uncorrectable event is fatal when its severity bit is set and non-fatal when that bit is clear. It sets device status bit 2 (fatal) or bit 1 (non-fatal). A fatal message (3'b100) needs serrEn or fatRptEn. A non-fatal message (3'b010) needs serrEn or nfRptEn.
- R5: A masked uncorrectable event still sets its uncorrectable status bit and its detected bit in device status. It raises no log request and sends no message.
- R6: An unmasked uncorrectable event pulses logReq for one cycle. logBit carries the one-hot error bit and logHdr carries the event's header-valid flag.
- R7: An unsupported-request event (bit 11) also sets device status bit 3. No uncorrectable message is sent for it when both urRptEn and serrEn are clear.
- R8: A non-fatal event flagged as advisory sets correctable bit 5, its uncorrectable status bit and device status bit 0. If correctable mask bit 5 is clear, it logs when its uncorrectable mask bit is clear. It also sends a 3'b001 message when corRptEn is high, and for an unsupported request also urRptEn. An advisory flag on a fatal error is ignored.
- R9: When logOvf is high while logReq is high, evReady is low for that cycle and any event offered then is dropped. At the next edge the block applies correctable bit 7 through the path of R3, and the message carries the source ID of the event that logged.
- R10: msgValid is a one-cycle pulse per reported event, with a one-hot msgSev and the event's source ID.
- R11: The status registers are write-one-to-clear through devClr, corClr and uncClr. A bit that is set by an event in the cycle it is cleared stays set.
- R12: sevWe loads sevWd, restricted to supported bits, into the severity register. Later events are classified with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Error event present |
| evReady | output | 1 | Low during the overflow injection cycle |
| evStatus | input | 16 | Error status bit of the event |
| evCor | input | 1 | Event is in the correctable class |
| evAdv | input | 1 | Event may be reported as advisory |
| evHdr | input | 1 | Event has a valid header to log |
| evSrc | input | 16 | Requester source ID |
| uncMask | input | 16 | Uncorrectable mask |
| corMask | input | 8 | Correctable mask |
| sevWe | input | 1 | Severity register write strobe |
| sevWd | input | 16 | Severity register write data |
| corRptEn | input | 1 | Correctable reporting enable |
| nfRptEn | input | 1 | Non-fatal reporting enable |
| fatRptEn | input | 1 | Fatal reporting enable |
| urRptEn | input | 1 | Unsupported-request reporting enable |
| serrEn | input | 1 | System error enable |
| devClr | input | 4 | Write-one-to-clear for device status |
| corClr | input | 8 | Write-one-to-clear for correctable status |
| uncClr | input | 16 | Write-one-to-clear for uncorrectable status |
| devSta | output | 4 | Device status: 0 correctable, 1 non-fatal, 2 fatal, 3 unsupported request |
| corSta | output | 8 | Correctable status |
| uncSta | output | 16 | Uncorrectable status |
| uncSev | output | 16 | Severity register |
| msgValid | output | 1 | Message pulse |
| msgSev | output | 3 | One-hot severity: 0 correctable, 1 non-fatal, 2 fatal |
| msgSrc | output | 16 | Message source ID |
| logReq | output | 1 | Header log request pulse |
| logBit | output | 16 | One-hot uncorrectable bit being logged |
| logHdr | output | 1 | Header-valid flag of the logged event |
| logOvf | input | 1 | Recorder reports overflow for the current logReq |

## Verification
Each event's effects appear at the ports one edge after it is accepted. A bad severity or mask decision therefore shows up at once as a wrong message severity, or as a message that should not be there or is missing. A corrupted sticky status bit stays visible until it is cleared, so a status check made right after each event catches it. A mistake in the overflow handling shows up two edges after the original event, as a missing bit 7 or a second message with the wrong source ID.

// File: rtl/errPkg.sv
package errPkg;
  localparam int UNC_W = 16;
  localparam int COR_W = 8;
  localparam int DEV_W = 4;
  localparam int SEV_W = 3;

  localparam int UR_BIT  = 11;
  localparam int ADV_BIT = 5;
  localparam int HLO_BIT = 7;

  localparam int DEV_COR = 0;
  localparam int DEV_NF  = 1;
  localparam int DEV_FAT = 2;
  localparam int DEV_UR  = 3;

  localparam int SEV_COR = 0;
  localparam int SEV_NF  = 1;
  localparam int SEV_FAT = 2;

  typedef struct packed {
    logic [DEV_W-1:0] setDev;
    logic [COR_W-1:0] setCor;
    logic [UNC_W-1:0] setUnc;
    logic             msgFire;
    logic [SEV_W-1:0] msgSev;
    logic             logFire;
    logic             holdSrc;
    logic             useHeld;
  } errStrobe_t;
endpackage

// File: rtl/errDecide.sv
module errDecide
  import errPkg::*;
#(
  parameter logic [UNC_W-1:0] UNC_SUP = 16'hFFFF,
  parameter logic [COR_W-1:0] COR_SUP = 8'hFF
) (
  input  logic             evValid,
  input  logic [UNC_W-1:0] evStatus,
  input  logic             evCor,
  input  logic             evAdv,
  input  logic             logReq,
  input  logic             logOvf,
  input  logic [UNC_W-1:0] uncMask,
  input  logic [COR_W-1:0] corMask,
  input  logic [UNC_W-1:0] sevReg,
  input  logic             corRptEn,
  input  logic             nfRptEn,
  input  logic             fatRptEn,
  input  logic             urRptEn,
  input  logic             serrEn,
  output logic             evReady,
  output errStrobe_t       st
);
  logic             ovfInj;
  logic [COR_W-1:0] corBits;
  logic [UNC_W-1:0] uncBits;
  logic             corOne;
  logic             uncOne;
  logic             isUr;
  logic             isFatal;
  logic             uncMasked;

  assign ovfInj  = logReq & logOvf;
  assign evReady = ~ovfInj;
  assign corBits = ovfInj ? COR_W'(1) << HLO_BIT : (evStatus[COR_W-1:0] & COR_SUP);
  assign uncBits = evStatus & UNC_SUP;
  assign corOne  = (corBits != '0) && ((corBits & (corBits - 1'b1)) == '0);
  assign uncOne  = (uncBits != '0) && ((uncBits & (uncBits - 1'b1)) == '0);
  assign isUr    = uncBits[UR_BIT];
  assign isFatal = |(uncBits & sevReg);
  assign uncMasked = |(uncBits & uncMask);

  always_comb begin
    st = '0;
    st.useHeld = ovfInj;
    st.holdSrc = evValid & ~ovfInj;
    if (ovfInj || (evValid && evCor && corOne)) begin
      st.setDev[DEV_COR] = 1'b1;
      st.setCor          = corBits;
      if (!(|(corBits & corMask)) && corRptEn) begin
        st.msgFire = 1'b1;
        st.msgSev[SEV_COR] = 1'b1;
      end
    end else if (evValid && !evCor && uncOne) begin
      st.setUnc          = uncBits;
      st.setDev[DEV_UR]  = isUr;
      if (!isFatal && evAdv) begin
        st.setDev[DEV_COR]  = 1'b1;
        st.setCor[ADV_BIT]  = 1'b1;
        if (!corMask[ADV_BIT]) begin
          st.logFire = ~uncMasked;
          if (corRptEn && !(isUr && !urRptEn)) begin
            st.msgFire = 1'b1;
            st.msgSev[SEV_COR] = 1'b1;
          end
        end
      end else begin
        st.setDev[isFatal ? DEV_FAT : DEV_NF] = 1'b1;
        if (!uncMasked) begin
          st.logFire = 1'b1;
          if (!(isUr && !urRptEn && !serrEn)) begin
            if (isFatal && (serrEn || fatRptEn)) begin
              st.msgFire = 1'b1;
              st.msgSev[SEV_FAT] = 1'b1;
            end else if (!isFatal && (serrEn || nfRptEn)) begin
              st.msgFire = 1'b1;
              st.msgSev[SEV_NF] = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/errStore.sv
module errStore
  import errPkg::*;
#(
  parameter int               SRC_W       = 16,
  parameter logic [UNC_W-1:0] UNC_SUP     = 16'hFFFF,
  parameter logic [UNC_W-1:0] SEV_DEFAULT = 16'h0317
) (
  input  logic             clk,
  input  logic             rstN,
  input  errStrobe_t       st,
  input  logic [SRC_W-1:0] evSrc,
  input  logic             evHdr,
  input  logic             sevWe,
  input  logic [UNC_W-1:0] sevWd,
  input  logic [DEV_W-1:0] devClr,
  input  logic [COR_W-1:0] corClr,
  input  logic [UNC_W-1:0] uncClr,
  output logic [DEV_W-1:0] devSta,
  output logic [COR_W-1:0] corSta,
  output logic [UNC_W-1:0] uncSta,
  output logic [UNC_W-1:0] sevReg,
  output logic             msgValid,
  output logic [SEV_W-1:0] msgSev,
  output logic [SRC_W-1:0] msgSrc,
  output logic             logReq,
  output logic [UNC_W-1:0] logBit,
  output logic             logHdr
);
  logic [SRC_W-1:0] srcHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devSta   <= '0;
      corSta   <= '0;
      uncSta   <= '0;
      sevReg   <= SEV_DEFAULT & UNC_SUP;
      msgValid <= 1'b0;
      msgSev   <= '0;
      msgSrc   <= '0;
      logReq   <= 1'b0;
      logBit   <= '0;
      logHdr   <= 1'b0;
      srcHold  <= '0;
    end else begin
      devSta   <= (devSta & ~devClr) | st.setDev;
      corSta   <= (corSta & ~corClr) | st.setCor;
      uncSta   <= (uncSta & ~uncClr) | st.setUnc;
      if (sevWe) sevReg <= sevWd & UNC_SUP;
      if (st.holdSrc) srcHold <= evSrc;
      msgValid <= st.msgFire;
      msgSev   <= st.msgFire ? st.msgSev : '0;
      if (st.msgFire) msgSrc <= st.useHeld ? srcHold : evSrc;
      logReq   <= st.logFire;
      logBit   <= st.logFire ? st.setUnc : '0;
      logHdr   <= st.logFire & evHdr;
    end
  end
endmodule

// File: rtl/errSignal.sv
module errSignal
  import errPkg::*;
#(
  parameter int               SRC_W       = 16,
  parameter logic [UNC_W-1:0] UNC_SUP     = 16'hFFFF,
  parameter logic [COR_W-1:0] COR_SUP     = 8'hFF,
  parameter logic [UNC_W-1:0] SEV_DEFAULT = 16'h0317
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  output logic             evReady,
  input  logic [UNC_W-1:0] evStatus,
  input  logic             evCor,
  input  logic             evAdv,
  input  logic             evHdr,
  input  logic [SRC_W-1:0] evSrc,
  input  logic [UNC_W-1:0] uncMask,
  input  logic [COR_W-1:0] corMask,
  input  logic             sevWe,
  input  logic [UNC_W-1:0] sevWd,
  input  logic             corRptEn,
  input  logic             nfRptEn,
  input  logic             fatRptEn,
  input  logic             urRptEn,
  input  logic             serrEn,
  input  logic [DEV_W-1:0] devClr,
  input  logic [COR_W-1:0] corClr,
  input  logic [UNC_W-1:0] uncClr,
  output logic [DEV_W-1:0] devSta,
  output logic [COR_W-1:0] corSta,
  output logic [UNC_W-1:0] uncSta,
  output logic [UNC_W-1:0] uncSev,
  output logic             msgValid,
  output logic [SEV_W-1:0] msgSev,
  output logic [SRC_W-1:0] msgSrc,
  output logic             logReq,
  output logic [UNC_W-1:0] logBit,
  output logic             logHdr,
  input  logic             logOvf
);
  errStrobe_t strobe;

  errDecide #(.UNC_SUP(UNC_SUP), .COR_SUP(COR_SUP)) u_decide (
    .evValid(evValid), .evStatus(evStatus), .evCor(evCor), .evAdv(evAdv),
    .logReq(logReq), .logOvf(logOvf), .uncMask(uncMask), .corMask(corMask),
    .sevReg(uncSev), .corRptEn(corRptEn), .nfRptEn(nfRptEn),
    .fatRptEn(fatRptEn), .urRptEn(urRptEn), .serrEn(serrEn),
    .evReady(evReady), .st(strobe)
  );

  errStore #(.SRC_W(SRC_W), .UNC_SUP(UNC_SUP), .SEV_DEFAULT(SEV_DEFAULT)) u_store (
    .clk(clk), .rstN(rstN), .st(strobe), .evSrc(evSrc), .evHdr(evHdr),
    .sevWe(sevWe), .sevWd(sevWd), .devClr(devClr), .corClr(corClr),
    .uncClr(uncClr), .devSta(devSta), .corSta(corSta), .uncSta(uncSta),
    .sevReg(uncSev), .msgValid(msgValid), .msgSev(msgSev), .msgSrc(msgSrc),
    .logReq(logReq), .logBit(logBit), .logHdr(logHdr)
  );
endmodule

// File: rtl/errSignalChk.sv
module errSignalChk
  import errPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             evValid,
  input logic             evReady,
  input logic [UNC_W-1:0] evStatus,
  input logic             evCor,
  input logic             evAdv,
  input logic [UNC_W-1:0] uncMask,
  input logic [COR_W-1:0] corClr,
  input logic [COR_W-1:0] corSta,
  input logic             msgValid,
  input logic [SEV_W-1:0] msgSev,
  input logic             logReq,
  input logic [UNC_W-1:0] logBit,
  input logic             logOvf
);
  // R10
  msg_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $onehot(msgSev));

  // R6
  log_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    logReq |-> $onehot(logBit));

  // R2
  empty_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evReady && evStatus == '0) |=> (!msgValid && !logReq));

  // R5
  masked_unc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evReady && !evCor && !evAdv && $onehot(evStatus) && |(evStatus & uncMask))
      |=> (!msgValid && !logReq));

  // R9
  overflow_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (logReq && logOvf) |=> (corSta[HLO_BIT] && !logReq));

  // R11
  sticky_cor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (corClr == '0) |=> ((corSta & $past(corSta)) == $past(corSta)));
endmodule

bind errSignal errSignalChk u_errSignalChk (
  .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady),
  .evStatus(evStatus), .evCor(evCor), .evAdv(evAdv), .uncMask(uncMask),
  .corClr(corClr), .corSta(corSta), .msgValid(msgValid), .msgSev(msgSev),
  .logReq(logReq), .logBit(logBit), .logOvf(logOvf)
);

// File: tb/test_errSignal.sv
`timescale 1ns/1ps
module test_errSignal;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0, evCor = 1'b0, evAdv = 1'b0, evHdr = 1'b0;
  logic        evReady;
  logic [15:0] evStatus = '0, evSrc = '0, uncMask = '0, sevWd = '0, uncClr = '0;
  logic [7:0]  corMask = '0, corClr = '0;
  logic [3:0]  devClr = '0;
  logic        sevWe = 1'b0, corRptEn = 1'b0, nfRptEn = 1'b0, fatRptEn = 1'b0;
  logic        urRptEn = 1'b0, serrEn = 1'b0, ovfMode = 1'b0;
  logic [3:0]  devSta;
  logic [7:0]  corSta;
  logic [15:0] uncSta, uncSev, msgSrc, logBit;
  logic        msgValid, logReq, logHdr, logOvf;
  logic [2:0]  msgSev;
  int          nChk = 0, nFail = 0;
  logic [18:0] expQ[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;
  assign logOvf = ovfMode & logReq;

  errSignal i_errSignal (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady),
    .evStatus(evStatus), .evCor(evCor), .evAdv(evAdv), .evHdr(evHdr),
    .evSrc(evSrc), .uncMask(uncMask), .corMask(corMask), .sevWe(sevWe),
    .sevWd(sevWd), .corRptEn(corRptEn), .nfRptEn(nfRptEn),
    .fatRptEn(fatRptEn), .urRptEn(urRptEn), .serrEn(serrEn),
    .devClr(devClr), .corClr(corClr), .uncClr(uncClr), .devSta(devSta),
    .corSta(corSta), .uncSta(uncSta), .uncSev(uncSev), .msgValid(msgValid),
    .msgSev(msgSev), .msgSrc(msgSrc), .logReq(logReq), .logBit(logBit),
    .logHdr(logHdr), .logOvf(logOvf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectMsg(input logic [2:0] sev, input logic [15:0] src);
    expQ.push_back({sev, src});
  endtask

  // monitor: pops the scoreboard whenever a message appears (R10)
  always @(negedge clk) begin
    if (rstN && msgValid && !done) begin
      nChk++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R10 unexpected message actual=%h expected=none", {msgSev, msgSrc});
      end else begin
        logic [18:0] e;
        e = expQ.pop_front();
        if ({msgSev, msgSrc} !== e) begin
          nFail++;
          $display("FAIL R10 message actual=%h expected=%h", {msgSev, msgSrc}, e);
        end
      end
    end
  end

  task automatic ev(input logic [15:0] s, input logic c, input logic a,
                    input logic h, input logic [15:0] src);
    @(negedge clk);
    evValid = 1'b1; evStatus = s; evCor = c; evAdv = a; evHdr = h; evSrc = src;
    @(negedge clk);
    evValid = 1'b0; evStatus = '0; evCor = 1'b0; evAdv = 1'b0; evHdr = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk);
    devClr = '1; corClr = '1; uncClr = '1;
    @(negedge clk);
    devClr = '0; corClr = '0; uncClr = '0;
  endtask

  task automatic finish();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 devSta", devSta, 0);
    chk("R1 corSta", corSta, 0);
    chk("R1 uncSta", uncSta, 0);
    chk("R1 severity default", uncSev, 32'h0317);
    chk("R1 idle", {msgValid, logReq, evReady}, 3'b001);

    // R3 correctable reported
    corRptEn = 1'b1;
    expectMsg(3'b001, 16'h0102);
    ev(16'h0002, 1, 0, 0, 16'h0102);
    chk("R3 corSta", corSta, 8'h02);
    chk("R3 devSta", devSta, 4'h1);
    @(negedge clk);
    chk("R10 single pulse", msgValid, 0);
    clearAll();
    chk("R11 cleared", {devSta, corSta, uncSta}, 0);

    // R3 masked correctable
    corMask = 8'h02;
    ev(16'h0002, 1, 0, 0, 16'h0103);
    chk("R3 masked still sets status", corSta, 8'h02);
    corMask = '0;
    clearAll();

    // R2 rejected events
    ev(16'h0003, 0, 0, 0, 16'h0104);
    chk("R2 multi-bit", {devSta, uncSta, logReq}, 0);
    ev(16'h0000, 0, 0, 0, 16'h0105);
    chk("R2 zero", {devSta, uncSta, logReq}, 0);
    ev(16'h0100, 1, 0, 0, 16'h0106);
    chk("R2 correctable outside class", {devSta, corSta}, 0);
    corRptEn = 1'b0;

    // R4 / R6 fatal by default severity
    fatRptEn = 1'b1;
    expectMsg(3'b100, 16'h0200);
    ev(16'h0010, 0, 0, 1, 16'h0200);
    chk("R4 fatal devSta", devSta, 4'h4);
    chk("R4 uncSta", uncSta, 16'h0010);
    chk("R6 log request", {logReq, logHdr, logBit}, {1'b1, 1'b1, 16'h0010});
    fatRptEn = 1'b0;
    clearAll();

    // R4 non-fatal without enable, then with serrEn
    ev(16'h0008, 0, 0, 0, 16'h0300);
    chk("R4 nonfatal devSta", devSta, 4'h2);
    chk("R6 log without header", {logReq, logHdr}, 2'b10);
    serrEn = 1'b1;
    expectMsg(3'b010, 16'h0301);
    ev(16'h0020, 0, 0, 0, 16'h0301);
    chk("R4 nonfatal via serr", uncSta, 16'h0028);
    serrEn = 1'b0;
    clearAll();

    // R5 masked uncorrectable
    uncMask = 16'h0200; fatRptEn = 1'b1;
    ev(16'h0200, 0, 0, 1, 16'h0302);
    chk("R5 status set", {devSta, uncSta}, {4'h4, 16'h0200});
    chk("R5 no log", logReq, 0);
    uncMask = '0; fatRptEn = 1'b0;
    clearAll();

    // R7 unsupported request
    nfRptEn = 1'b1;
    ev(16'h0800, 0, 0, 0, 16'h0400);
    chk("R7 devSta", devSta, 4'hA);
    chk("R7 log", logReq, 1);
    urRptEn = 1'b1;
    expectMsg(3'b010, 16'h0401);
    ev(16'h0800, 0, 0, 0, 16'h0401);
    chk("R7 uncSta", uncSta, 16'h0800);
    nfRptEn = 1'b0; urRptEn = 1'b0;
    clearAll();

    // R8 advisory
    corRptEn = 1'b1;
    expectMsg(3'b001, 16'h0500);
    ev(16'h0040, 0, 1, 1, 16'h0500);
    chk("R8 corSta", corSta, 8'h20);
    chk("R8 uncSta", uncSta, 16'h0040);
    chk("R8 devSta", devSta, 4'h1);
    chk("R8 log", {logReq, logBit}, {1'b1, 16'h0040});
    uncMask = 16'h0040;
    expectMsg(3'b001, 16'h0501);
    ev(16'h0040, 0, 1, 0, 16'h0501);
    chk("R8 masked no log", logReq, 0);
    uncMask = '0;
    clearAll();
    ev(16'h0800, 0, 1, 0, 16'h0502);
    chk("R8 advisory UR gated", {devSta, corSta}, {4'h9, 8'h20});
    clearAll();
    fatRptEn = 1'b1;
    expectMsg(3'b100, 16'h0503);
    ev(16'h0002, 0, 1, 0, 16'h0503);
    chk("R8 fatal not advisory", {devSta, corSta}, {4'h4, 8'h00});
    fatRptEn = 1'b0; corRptEn = 1'b0;
    clearAll();

    // R12 severity write
    @(negedge clk);
    sevWe = 1'b1; sevWd = 16'h0008;
    @(negedge clk);
    sevWe = 1'b0;
    chk("R12 severity loaded", uncSev, 16'h0008);
    fatRptEn = 1'b1;
    expectMsg(3'b100, 16'h0504);
    ev(16'h0008, 0, 0, 0, 16'h0504);
    chk("R12 reclassified fatal", devSta, 4'h4);
    fatRptEn = 1'b0;
    @(negedge clk);
    sevWe = 1'b1; sevWd = 16'h0317;
    @(negedge clk);
    sevWe = 1'b0;
    clearAll();

    // R9 log overflow injection
    nfRptEn = 1'b1; corRptEn = 1'b1; ovfMode = 1'b1;
    expectMsg(3'b010, 16'h0600);
    expectMsg(3'b001, 16'h0600);
    @(negedge clk);
    evValid = 1'b1; evStatus = 16'h0020; evHdr = 1'b1; evSrc = 16'h0600;
    @(negedge clk);
    chk("R9 stall", {logReq, evReady}, 2'b10);
    evStatus = 16'h0004; evHdr = 1'b0; evSrc = 16'h0777;
    @(negedge clk);
    evValid = 1'b0; evStatus = '0;
    chk("R9 overflow bit", corSta, 8'h80);
    chk("R9 offered event dropped", uncSta, 16'h0020);
    chk("R9 devSta", devSta, 4'h3);
    ovfMode = 1'b0; nfRptEn = 1'b0; corRptEn = 1'b0;
    clearAll();

    // R11 set wins over clear
    @(negedge clk);
    evValid = 1'b1; evCor = 1'b1; evStatus = 16'h0001; corClr = 8'h01;
    @(negedge clk);
    evValid = 1'b0; evCor = 1'b0; evStatus = '0; corClr = '0;
    chk("R11 set wins", corSta, 8'h01);

    repeat (2) @(negedge clk);
    chk("R10 all messages seen", expQ.size(), 0);
    finish();
  end
endmodule